// File: doc/BRIEF.md
# Repeating Stress Bit-Sequence Generator

This block emits a fixed stress bit stream one bit per clock, for use as the transmit-side source of a link self-test or as the expected stream of a receive-side checker. The period is 32,760 bits built from eight consecutive blocks. Block 0 is a 28-bit-register pseudo-random segment from one seed. Block 1 is a lone one followed by a long run of zeros. Block 2 is a pseudo-random segment from a second seed. Block 3 replays the block 0 sequence through a differential encoder. Blocks 4 to 7 repeat blocks 0 to 3 with every bit inverted.

An enable input gates progress. While it is low the generator freezes and drives zeros, so a downstream serializer can stall it freely. A start marker flags the first bit of every period, and the current block index is presented so that a checker can tell which part of the stream it is looking at.

Top module: `stress_seq_gen`

## Requirements
- R1: The stream repeats with a period of exactly 32,760 enabled cycles. `start_mark` is 1 only on the enabled cycle that carries the first bit of block 0, which is once per period.
- R2: Block 0 is 5437 bits of the recurrence x[n] = x[n-28] XOR x[n-25]. Its first 28 bits are the seed 28'h0080080, read most-significant bit first, so the block begins with 8 zeros, a one, 11 zeros, a one, 12 zeros and a one.
- R3: Block 1 is 72 bits: a single one followed by 71 zeros.
- R4: Block 2 is 5437 bits of the same recurrence seeded with 28'hFFFFFFF. It begins with 28 ones, 25 zeros, 3 ones and 22 zeros.
- R5: Block 3 is 5434 bits: the first 5434 bits of the block 0 sequence, differentially encoded. The encoder state is 0 before the first bit, an input 0 toggles the output and an input 1 holds it. The block begins 1010101001010101010110101010101011011010.
- R6: Blocks 4, 5, 6 and 7 are the bitwise inverses of blocks 0, 1, 2 and 3.
- R7: `block_idx` gives the block of the current bit (0 to 7). It changes only when a block's last bit is consumed, and then advances by one, wrapping from 7 to 0.
- R8: While `en` is 0, `pattern_bit` and `start_mark` are 0 and no state advances. When `en` returns to 1, the stream resumes at the bit that was pending.
- R9: A synchronous `rst` returns the generator to the first bit of block 0 from any point in the stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Consume and emit one bit this cycle |
| pattern_bit | output | 1 | Current stream bit (0 when `en` is low) |
| start_mark | output | 1 | First bit of the period is being emitted |
| block_idx | output | 3 | Index of the block of the current bit |

## Verification
The bench checks a full period plus a wrap into the next one. This exposes an off-by-one block length, which shifts every later bit and moves the second start marker, and a missing reseed at the 7-to-0 wrap, which corrupts the second period. The entry into block 3 is checked against the stated prefix. An encoder not cleared at the block boundary, or encoding with the wrong polarity, flips the first bits of block 3 or block 7. An enable gap mid-stream catches a design that keeps shifting while stalled, which would skip bits on resume. A reset mid-stream catches state that survives the reset.

// File: rtl/stress_seq_pkg.sv
package stress_seq_pkg;

  // Role of a block within one half of the period (blocks 4..7 reuse it, inverted)
  typedef enum logic [1:0] {
    KIND_RAND_A = 2'd0,
    KIND_RUN    = 2'd1,
    KIND_RAND_B = 2'd2,
    KIND_DIFF   = 2'd3
  } blk_kind_e;

  localparam int        DEF_LFSR_W   = 28;
  localparam int        DEF_TAP_HI   = 28;
  localparam int        DEF_TAP_LO   = 25;
  localparam int        DEF_RAND_LEN = 5437;
  localparam int        DEF_RUN_LEN  = 72;
  localparam int        DEF_DIFF_LEN = 5434;
  localparam logic [27:0] DEF_SEED_A = 28'h0080080;
  localparam logic [27:0] DEF_SEED_B = 28'hFFFFFFF;

  function automatic blk_kind_e kind_of(input logic [2:0] idx);
    return blk_kind_e'(idx[1:0]);
  endfunction

  // The shift register is reloaded before every block that reads it
  function automatic logic needs_reseed(input blk_kind_e k);
    return k != KIND_RUN;
  endfunction

endpackage

// File: rtl/stress_seq_lfsr.sv
module stress_seq_lfsr #(
  parameter int          W          = 28,
  parameter int          TAP_HI     = 28,
  parameter int          TAP_LO     = 25,
  parameter logic [W-1:0] RESET_SEED = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] seed_in,
  output logic         out_bit,
  output logic [W-1:0] state_q
);

  localparam int HI_IDX = W - 1;
  localparam int LO_IDX = W - 1 - (TAP_HI - TAP_LO);

  // Oldest bit leaves at the top, new bit enters at the bottom
  function automatic logic [W-1:0] advance(input logic [W-1:0] s);
    return {s[W-2:0], s[HI_IDX] ^ s[LO_IDX]};
  endfunction

  assign out_bit = state_q[HI_IDX];

  always_ff @(posedge clk) begin
    if (rst)       state_q <= RESET_SEED;
    else if (load) state_q <= seed_in;
    else if (step) state_q <= advance(state_q);
  end

  // R2: a nonzero seed never collapses to the all-zero lockup state
  assert_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  // R2, R4: a reload takes the seed presented in the previous cycle
  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> state_q == $past(seed_in));

endmodule

// File: rtl/stress_seq_diff.sv
module stress_seq_diff (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  input  logic data_in,
  output logic enc_bit,
  output logic state_q
);

  // A zero flips the line, a one keeps it
  function automatic logic encode(input logic prev, input logic d);
    return prev ^ ~d;
  endfunction

  assign enc_bit = encode(state_q, data_in);

  always_ff @(posedge clk) begin
    if (rst || clr) state_q <= 1'b0;
    else if (adv)   state_q <= enc_bit;
  end

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr && !adv) |=> state_q == 1'b0);

  assert_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && !data_in) |=> state_q != $past(state_q));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && data_in) |=> $stable(state_q));

endmodule

// File: rtl/stress_seq_ctrl.sv
module stress_seq_ctrl
  import stress_seq_pkg::*;
#(
  parameter int RAND_LEN = 5437,
  parameter int RUN_LEN  = 72,
  parameter int DIFF_LEN = 5434,
  parameter int POS_W    = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [2:0]       blk_idx,
  output logic [POS_W-1:0] bit_pos,
  output logic             wrap,
  output logic             first
);

  function automatic logic [POS_W-1:0] last_of(input blk_kind_e k);
    case (k)
      KIND_RUN:  return POS_W'(RUN_LEN - 1);
      KIND_DIFF: return POS_W'(DIFF_LEN - 1);
      default:   return POS_W'(RAND_LEN - 1);
    endcase
  endfunction

  logic [POS_W-1:0] last_pos;

  assign last_pos = last_of(kind_of(blk_idx));
  assign wrap     = en && (bit_pos == last_pos);
  assign first    = (blk_idx == 3'd0) && (bit_pos == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_idx <= 3'd0;
      bit_pos <= '0;
    end else if (en) begin
      if (bit_pos == last_pos) begin
        bit_pos <= '0;
        blk_idx <= blk_idx + 3'd1;
      end else begin
        bit_pos <= bit_pos + 1'b1;
      end
    end
  end

  assert_pos_in_block_R7: assert property (@(posedge clk) disable iff (rst)
    bit_pos <= last_pos);

  assert_block_step_R7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (blk_idx == $past(blk_idx) + 3'd1) && (bit_pos == '0));

  assert_block_steady_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap) |=> $stable(blk_idx));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(blk_idx) && $stable(bit_pos));

endmodule

// File: rtl/stress_seq_gen.sv
module stress_seq_gen
  import stress_seq_pkg::*;
#(
  parameter int          LFSR_W   = DEF_LFSR_W,
  parameter int          TAP_HI   = DEF_TAP_HI,
  parameter int          TAP_LO   = DEF_TAP_LO,
  parameter int          RAND_LEN = DEF_RAND_LEN,
  parameter int          RUN_LEN  = DEF_RUN_LEN,
  parameter int          DIFF_LEN = DEF_DIFF_LEN,
  parameter logic [LFSR_W-1:0] SEED_A = DEF_SEED_A,
  parameter logic [LFSR_W-1:0] SEED_B = DEF_SEED_B
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic       pattern_bit,
  output logic       start_mark,
  output logic [2:0] block_idx
);

  localparam int MAX_AB  = (RAND_LEN > DIFF_LEN) ? RAND_LEN : DIFF_LEN;
  localparam int MAX_LEN = (MAX_AB > RUN_LEN) ? MAX_AB : RUN_LEN;
  localparam int POS_W   = $clog2(MAX_LEN);

  logic [POS_W-1:0]  bit_pos;
  logic              seq_wrap;
  logic              seq_first;
  blk_kind_e         cur_kind;
  blk_kind_e         nxt_kind;
  logic              lfsr_load;
  logic              lfsr_step;
  logic [LFSR_W-1:0] lfsr_seed;
  logic [LFSR_W-1:0] lfsr_state;
  logic              lfsr_bit;
  logic              diff_adv;
  logic              diff_bit;
  logic              diff_state;
  logic              raw_bit;

  stress_seq_ctrl #(
    .RAND_LEN(RAND_LEN), .RUN_LEN(RUN_LEN), .DIFF_LEN(DIFF_LEN), .POS_W(POS_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .en(en),
    .blk_idx(block_idx), .bit_pos(bit_pos), .wrap(seq_wrap), .first(seq_first)
  );

  assign cur_kind  = kind_of(block_idx);
  assign nxt_kind  = kind_of(block_idx + 3'd1);
  assign lfsr_load = seq_wrap && needs_reseed(nxt_kind);
  assign lfsr_seed = (nxt_kind == KIND_RAND_B) ? SEED_B : SEED_A;
  assign lfsr_step = en && !seq_wrap;

  stress_seq_lfsr #(
    .W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .RESET_SEED(SEED_A)
  ) u_lfsr (
    .clk(clk), .rst(rst), .load(lfsr_load), .step(lfsr_step),
    .seed_in(lfsr_seed), .out_bit(lfsr_bit), .state_q(lfsr_state)
  );

  assign diff_adv = en && !seq_wrap && (cur_kind == KIND_DIFF);

  stress_seq_diff u_diff (
    .clk(clk), .rst(rst), .clr(seq_wrap), .adv(diff_adv),
    .data_in(lfsr_bit), .enc_bit(diff_bit), .state_q(diff_state)
  );

  always_comb begin
    unique case (cur_kind)
      KIND_RUN:  raw_bit = (bit_pos == '0);
      KIND_DIFF: raw_bit = diff_bit;
      default:   raw_bit = lfsr_bit;
    endcase
  end

  // Upper half of the period is the lower half inverted
  assign pattern_bit = en & (raw_bit ^ block_idx[2]);
  assign start_mark  = en & seq_first;

  // R1: closing block 7 rearms the first seed and returns to block 0
  assert_period_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (seq_wrap && block_idx == 3'd7) |=> (lfsr_state == SEED_A) && (block_idx == 3'd0));

  // R5: the differential block starts from a cleared encoder and the first seed
  assert_diff_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (seq_wrap && nxt_kind == KIND_DIFF) |=> (diff_state == 1'b0) && (lfsr_state == SEED_A));

  // R6: inside the inverted run block every bit after the first is one
  assert_run_inverted_R6: assert property (@(posedge clk) disable iff (rst)
    (en && block_idx == 3'd5 && bit_pos != '0) |-> pattern_bit);

  // R8: an idle cycle drives nothing
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !en |-> !pattern_bit && !start_mark);

endmodule

// File: tb/sim_stress_seq_gen.sv
`timescale 1ns/1ps
module sim_stress_seq_gen;

  localparam int PERIOD = 32760;
  localparam int LA = 5437;
  localparam int LR = 72;
  localparam int LD = 5434;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic       pattern_bit;
  logic       start_mark;
  logic [2:0] block_idx;

  always #2.5 clk = ~clk;

  stress_seq_gen u0 (
    .clk(clk), .rst(rst), .en(en),
    .pattern_bit(pattern_bit), .start_mark(start_mark), .block_idx(block_idx)
  );

  typedef struct {
    logic       b;
    logic       s;
    logic [2:0] k;
    int         req;
    int         pos;
  } exp_t;

  exp_t q[$];
  bit   ref_bit [PERIOD];
  int   ref_blk [PERIOD];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   pos      = 0;
  int   req_over = 0;
  bit   done     = 0;

  function automatic string rname(input int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input int r, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rname(r), what, act, exp);
    end
  endtask

  // Expected stream from the requirement text, by direct recurrence on a bit history
  task automatic build_ref();
    bit ha [LA];
    bit hb [LA];
    bit hd [LD];
    bit o;
    int p;
    logic [27:0] sa = 28'h0080080;
    logic [27:0] sb = 28'hFFFFFFF;
    logic [39:0] dpre = 40'b1010101001010101010110101010101011011010;
    for (int i = 0; i < 28; i++) begin
      ha[i] = sa[27-i];
      hb[i] = sb[27-i];
    end
    for (int i = 28; i < LA; i++) begin
      ha[i] = ha[i-28] ^ ha[i-25];
      hb[i] = hb[i-28] ^ hb[i-25];
    end
    o = 1'b0;
    for (int i = 0; i < LD; i++) begin
      if (!ha[i]) o = ~o;
      hd[i] = o;
    end
    // Self-check of the model against the stated prefixes
    for (int i = 0; i < 34; i++)
      check(2, "block0 prefix", ha[i], (i == 8 || i == 20 || i == 33) ? 1 : 0);
    for (int i = 0; i < 78; i++)
      check(4, "block2 prefix", hb[i], (i < 28 || (i >= 53 && i < 56)) ? 1 : 0);
    for (int i = 0; i < 40; i++)
      check(5, "block3 prefix", hd[i], dpre[39-i]);
    p = 0;
    for (int h = 0; h < 2; h++) begin
      for (int i = 0; i < LA; i++) begin ref_bit[p] = ha[i] ^ h[0]; ref_blk[p] = 4*h;     p++; end
      for (int i = 0; i < LR; i++) begin ref_bit[p] = (i == 0) ^ h[0]; ref_blk[p] = 4*h+1; p++; end
      for (int i = 0; i < LA; i++) begin ref_bit[p] = hb[i] ^ h[0]; ref_blk[p] = 4*h+2; p++; end
      for (int i = 0; i < LD; i++) begin ref_bit[p] = hd[i] ^ h[0]; ref_blk[p] = 4*h+3; p++; end
    end
    check(1, "model period", p, PERIOD);
  endtask

  task automatic run_en(input int n);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = 1'b1;
      e.b = ref_bit[pos];
      e.s = (pos == 0);
      e.k = 3'(ref_blk[pos]);
      e.req = (req_over != 0) ? req_over : ((ref_blk[pos] >= 4) ? 6 : ref_blk[pos] + 2);
      e.pos = pos;
      q.push_back(e);
      pos = (pos + 1) % PERIOD;
    end
  endtask

  task automatic run_idle(input int n);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = 1'b0;
      e.b = 1'b0;
      e.s = 1'b0;
      e.k = 3'(ref_blk[pos]);
      e.req = 8;
      e.pos = pos;
      q.push_back(e);
    end
  endtask

  // Monitor: scoreboard pops one expectation per cycle, mid-cycle
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        e = q.pop_front();
        check(e.req, $sformatf("bit at pos %0d", e.pos), pattern_bit, e.b);
        check((e.req == 8 || e.req == 9) ? e.req : 1,
              $sformatf("start_mark at pos %0d", e.pos), start_mark, e.s);
        check((e.req == 8 || e.req == 9) ? e.req : 7,
              $sformatf("block_idx at pos %0d", e.pos), block_idx, e.k);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    build_ref();
    repeat (3) @(negedge clk);
    #1;
    // R9: reset state
    check(9, "reset block_idx", block_idx, 0);
    check(9, "reset pattern_bit (idle)", pattern_bit, 0);
    check(9, "reset start_mark (idle)", start_mark, 0);
    @(negedge clk);
    rst = 1'b0;
    pos = 0;
    run_en(200);
    run_idle(7);                          // R8: stall mid block 0
    run_en(PERIOD - 200 + 300);           // R1: through wrap into second period
    run_idle(3);
    run_en(50);
    @(negedge clk);                       // R9: reset mid-stream
    en  = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    pos = 0;
    req_over = 9;
    run_en(60);
    req_over = 0;
    run_en(100);
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    finish_run();
  end

endmodule